// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block derives two audio bit-rate clock enables from a set of external master-clock inputs. All logic runs on one system clock. Each external master clock appears as a one-cycle strobe on `srcTick`, so the block stays fully synchronous.

The block has two channels, and they are independent. Channel 0 is meant for master clocks that are multiples of 44100 Hz. Channel 1 is meant for multiples of 48000 Hz. Each channel picks one master-clock input through a 3-bit source code. It then divides that input in two stages: a power-of-four prescaler followed by an 8-bit counter. The channel emits a one-cycle pulse on `rateTick` once per full division period.

A small register port holds three registers: one control word and two 10-bit ratio words. Writing a channel's ratio word or the control word restarts that channel from zero, so the first period after the write is a full one. One control bit chooses which channel drives the master output `mstrTick`.

Top module: `audio_brg`

## Requirements
- R1: After reset, the control register reads 0x00000000 and both ratio registers read 0x002. Both channels then divide input 0 by 6.
- R2: A ratio register (address 1 for channel 0, address 2 for channel 1) keeps only write-data bits [9:0]. Higher bits are dropped, and the register reads back zero-extended.
- R3: A write to the control register (address 0) stores only the bits under mask 0x80FF0000. All other bits read back as zero.
- R4: A ratio word with bits [9:8] = p and bits [7:0] = m divides by (2 × 4^p) × (m + 1). A channel pulses exactly once per that many ticks of its selected input.
- R5: The source code for channel 0 sits in control bits [22:20] and the code for channel 1 in bits [18:16]. Code 0 selects srcTick[0], code 1 selects srcTick[1], code 4 selects srcTick[2], and code 2 selects srcTick[3]. Ticks on inputs that are not selected are not counted.
- R6: A channel whose source code is 3, 5, 6 or 7 never pulses, and its count stays at zero.
- R7: A write to a channel's ratio register, or to the control register, clears that channel's count. The tick present in the write cycle is discarded, and the first pulse comes after exactly one full period of later ticks.
- R8: Each pulse on rateTick lasts exactly one system cycle. A pulse appears in the cycle after the edge that sampled the final tick of a period.
- R9: `mstrTick` follows channel 1 when control bit 31 is 1, and channel 0 when it is 0.
- R10: Writing one channel's ratio register does not disturb the other channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 4 | One-cycle strobes, one per master-clock input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 ratio ch0, 2 ratio ch1 |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map as wrAddr |
| rdData | output | 32 | Combinational read data |
| rateTick | output | 2 | Divided clock enables; bit 0 is the 44.1 kHz-family channel, bit 1 the 48 kHz-family channel |
| mstrTick | output | 1 | Selected channel's enable |

## Verification
The bench measures the period of every prescale code at post-divider counts of 1, 2 and 256. A power-of-four shift that is off by one bit, or a post-divider that treats the field as N rather than N−1, shows up as a period that is 2× or 4× off, or one step too long.

Other checks cover source handling:
- It drives ticks only on the inputs a code does not select. A design that scrambles the code table, or counts any input, then produces pulses where there should be none.
- It sets invalid codes to catch a design that falls back to input 0.

For restart, the bench rewrites a ratio in the middle of a period. A design that skips the restart, or counts the tick in the write cycle, gives a short first period. A design that restarts both channels moves the other channel's pulse.

A cycle model checks every cycle of randomly timed ticks and random reprogramming.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int NCH        = 2;
  localparam int NSRC       = 4;
  localparam int SRC_IDX_W  = $clog2(NSRC);
  localparam int SRC_W      = 3;
  localparam int PCODE_W    = 2;
  localparam int NM1_W      = 8;
  localparam int RATIO_W    = PCODE_W + NM1_W;
  localparam int PRE_W      = 2 * (2**PCODE_W - 1) + 1;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;
  localparam int FIELD_W    = 4;
  localparam int FIELD0_LSB = 20;
  localparam int OUTSEL_BIT = DATA_W - 1;

  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(2);
  localparam logic [DATA_W-1:0]  CTRL_MASK = 32'h80FF_0000;
  localparam logic [ADDR_W-1:0]  ADDR_CTRL = '0;

  typedef struct packed {
    logic [SRC_W-1:0]   src;
    logic [PCODE_W-1:0] pre;
    logic [NM1_W-1:0]   nm1;
  } chCfg_t;

  typedef struct packed {
    logic [NCH-1:0] restart;
  } ctrlStb_t;

  typedef struct packed {
    logic                 valid;
    logic [SRC_IDX_W-1:0] idx;
  } srcSel_t;

  // code -> input index (0:in0, 1:in1, 4:in2, 2:in3)
  function automatic srcSel_t decodeSrc(input logic [SRC_W-1:0] code);
    srcSel_t s;
    s.valid = 1'b1;
    case (code)
      3'd0:    s.idx = SRC_IDX_W'(0);
      3'd1:    s.idx = SRC_IDX_W'(1);
      3'd4:    s.idx = SRC_IDX_W'(2);
      3'd2:    s.idx = SRC_IDX_W'(3);
      default: begin s.valid = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  // last prescaler count: 2*4^p - 1
  function automatic logic [PRE_W-1:0] preLast(input logic [PCODE_W-1:0] code);
    int sh;
    sh = 2 * int'(code) + 1;
    return PRE_W'((1 << sh) - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] ratioAddr(input int ch);
    return ADDR_W'(ch + 1);
  endfunction

  function automatic int fieldLsb(input int ch);
    return FIELD0_LSB - FIELD_W * ch;
  endfunction
endpackage

// File: rtl/brg_regs.sv
module brg_regs
  import brg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output chCfg_t [NCH-1:0]      cfg,
  output logic                  outSel,
  output ctrlStb_t              stb
);
  logic [RATIO_W-1:0] ratioQ [NCH];
  logic [FIELD_W-1:0] fieldQ [NCH];
  logic               outSelQ;
  logic               ctrlWr;
  logic [DATA_W-1:0]  ctrlWord;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign outSel = outSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSelQ <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        ratioQ[c] <= RATIO_RST;
        fieldQ[c] <= '0;
      end
    end else begin
      if (ctrlWr) begin
        outSelQ <= wrData[OUTSEL_BIT];
        for (int c = 0; c < NCH; c++)
          fieldQ[c] <= wrData[fieldLsb(c) +: FIELD_W];
      end
      for (int c = 0; c < NCH; c++)
        if (wrEn && (wrAddr == ratioAddr(c)))
          ratioQ[c] <= wrData[RATIO_W-1:0];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg[c].src         = fieldQ[c][SRC_W-1:0];
      cfg[c].pre         = ratioQ[c][RATIO_W-1 -: PCODE_W];
      cfg[c].nm1         = ratioQ[c][NM1_W-1:0];
      stb.restart[c]     = ctrlWr || (wrEn && (wrAddr == ratioAddr(c)));
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[OUTSEL_BIT] = outSelQ;
    for (int c = 0; c < NCH; c++)
      ctrlWord[fieldLsb(c) +: FIELD_W] = fieldQ[c];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_CTRL) rdData = ctrlWord;
    for (int c = 0; c < NCH; c++)
      if (rdAddr == ratioAddr(c)) rdData = DATA_W'(ratioQ[c]);
  end

  // R3: control register keeps only masked bits
  p_ctrl_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ctrlWord == ($past(wrData) & CTRL_MASK)))
    else $error("control mask violated");

  for (genvar g = 0; g < NCH; g++) begin : gChk
    // R2: ratio keeps low bits of the written word
    p_ratio_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && (wrAddr == ratioAddr(g))) |=> (ratioQ[g] == $past(wrData[RATIO_W-1:0])))
      else $error("ratio write not captured");
  end
endmodule

// File: rtl/brg_chan.sv
module brg_chan
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  srcTick,
  input  chCfg_t           cfg,
  input  logic             restart,
  output logic             pulse
);
  srcSel_t          sel;
  logic             tickSel;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preEnd;
  logic [NM1_W-1:0] postCnt;
  logic             preWrap;

  always_comb begin
    sel     = decodeSrc(cfg.src);
    tickSel = sel.valid && srcTick[sel.idx];
    preEnd  = preLast(cfg.pre);
    preWrap = tickSel && (preCnt == preEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
      pulse   <= 1'b0;
    end else if (restart || !sel.valid) begin
      preCnt  <= '0;
      postCnt <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (preWrap) begin
        preCnt <= '0;
        if (postCnt == cfg.nm1) begin
          postCnt <= '0;
          pulse   <= 1'b1;
        end else begin
          postCnt <= postCnt + 1'b1;
        end
      end else if (tickSel) begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R7: a restart leaves the channel at zero with no pulse
  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (preCnt == '0 && postCnt == '0 && !pulse))
    else $error("restart did not clear channel");

  // R6: an unmapped source code silences the channel
  p_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sel.valid |=> !pulse)
    else $error("pulse from invalid source");

  // R8: pulses are one cycle wide
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse)
    else $error("pulse wider than one cycle");

  // R4: a pulse is always preceded by a counted tick
  p_pulse_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulse) |-> $past(tickSel))
    else $error("pulse without source tick");

  // R4: counters stay inside the programmed range
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt <= preEnd) && (postCnt <= cfg.nm1))
    else $error("counter out of range");
endmodule

// File: rtl/brg_dp.sv
module brg_dp
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  srcTick,
  input  chCfg_t [NCH-1:0] cfg,
  input  ctrlStb_t         stb,
  input  logic             outSel,
  output logic [NCH-1:0]   rateTick,
  output logic             mstrTick
);
  for (genvar g = 0; g < NCH; g++) begin : gCh
    brg_chan u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .srcTick (srcTick),
      .cfg     (cfg[g]),
      .restart (stb.restart[g]),
      .pulse   (rateTick[g])
    );
  end

  assign mstrTick = outSel ? rateTick[NCH-1] : rateTick[0];
endmodule

// File: rtl/audio_brg.sv
module audio_brg
  import brg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NCH-1:0]    rateTick,
  output logic              mstrTick
);
  chCfg_t [NCH-1:0] cfg;
  ctrlStb_t         stb;
  logic             outSel;

  brg_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cfg    (cfg),
    .outSel (outSel),
    .stb    (stb)
  );

  brg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcTick  (srcTick),
    .cfg      (cfg),
    .stb      (stb),
    .outSel   (outSel),
    .rateTick (rateTick),
    .mstrTick (mstrTick)
  );
endmodule

// File: tb/sim_audio_brg.sv
module sim_audio_brg;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcTick = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [1:0]  rateTick;
  logic        mstrTick;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  bit  mRun = 0;
  int  mRatio [2];
  int  mSrc [2];
  int  mCnt [2];
  bit  mOut;
  bit  expP [2];
  bit  prevT [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_brg u0 (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .rateTick(rateTick),
    .mstrTick(mstrTick)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int srcIdx(input int code);
    case (code)
      0: return 0;
      1: return 1;
      4: return 2;
      2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int divOf(input int r);
    return (2 << (2 * ((r >> 8) & 3))) * ((r & 255) + 1);
  endfunction

  // one system cycle: drive, clock, update model, sample at negedge
  task automatic cyc(input logic [3:0] t, input bit we, input logic [1:0] a,
                     input logic [31:0] d);
    srcTick = t; wrEn = we; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      int idx;
      idx = srcIdx(mSrc[c]);
      expP[c] = 1'b0;
      if ((we && (a == 0 || a == 2'(c + 1))) || idx < 0) begin
        mCnt[c] = 0;
      end else if (t[idx]) begin
        mCnt[c]++;
        if (mCnt[c] == divOf(mRatio[c])) begin
          mCnt[c] = 0;
          expP[c] = 1'b1;
        end
      end
    end
    if (we) begin
      if (a == 0) begin
        mOut = d[31]; mSrc[0] = int'(d[22:20]); mSrc[1] = int'(d[18:16]);
      end else if (a == 1) mRatio[0] = int'(d[9:0]);
      else if (a == 2) mRatio[1] = int'(d[9:0]);
    end
    @(negedge clk);
    wrEn = 1'b0;
    if (mRun) begin
      check(rateTick[0] == expP[0], "R4", "ch0 pulse vs model", rateTick[0], expP[0]);
      check(rateTick[1] == expP[1], "R5", "ch1 pulse vs model", rateTick[1], expP[1]);
      check(mstrTick == (mOut ? expP[1] : expP[0]), "R9", "master pulse vs model",
            mstrTick, mOut ? expP[1] : expP[0]);
      for (int c = 0; c < 2; c++)
        check(!(rateTick[c] && prevT[c]), "R8", "pulse two cycles wide", 1, 0);
    end
    prevT[0] = rateTick[0]; prevT[1] = rateTick[1];
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic waitPulse(input int ch, input logic [3:0] t, input int limit,
                           output int n);
    n = 0;
    do begin
      cyc(t, 0, 2'd0, 32'd0);
      n++;
    end while (!rateTick[ch] && n < limit);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL WD watchdog expired got=0x%0h exp=0x%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, n2, cntA, cntB, aFirst, bFirst;
    int codes [4] = '{0, 1, 4, 2};
    void'($urandom(32'd4711));
    mRatio[0] = 2; mRatio[1] = 2; mSrc[0] = 0; mSrc[1] = 0; mOut = 0;
    mCnt[0] = 0; mCnt[1] = 0; prevT[0] = 0; prevT[1] = 0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check(v == 32'h0, "R1", "ctrl in reset", v, 0);
    rstN = 1'b1;
    mRun = 1;
    rd(2'd0, v); check(v == 32'h0, "R1", "ctrl after reset", v, 0);
    rd(2'd1, v); check(v == 32'h2, "R1", "ratio0 after reset", v, 2);
    rd(2'd2, v); check(v == 32'h2, "R1", "ratio1 after reset", v, 2);
    waitPulse(0, 4'b0001, 100, n);
    check(n == 6, "R1", "first period after reset", n, 6);
    check(rateTick[1] == 1'b1, "R1", "ch1 pulse after reset", rateTick[1], 1);
    waitPulse(0, 4'b0001, 100, n);
    check(n == 6, "R4", "default period", n, 6);

    // R2: only bits [9:0] kept
    cyc(4'b0, 1, 2'd1, 32'hABCD_E705);
    rd(2'd1, v); check(v == 32'h305, "R2", "ratio0 readback", v, 32'h305);
    cyc(4'b0, 1, 2'd2, 32'hFFFF_FC00);
    rd(2'd2, v); check(v == 32'h0, "R2", "ratio1 upper bits dropped", v, 0);

    // R3 / R6: masked control, invalid code 7 silences both
    cyc(4'b0, 1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check(v == 32'h80FF_0000, "R3", "ctrl mask", v, 32'h80FF_0000);
    cntA = 0; cntB = 0;
    repeat (300) begin
      cyc(4'b1111, 0, 2'd0, 32'd0);
      cntA += rateTick[0]; cntB += rateTick[1];
    end
    check(cntA == 0, "R6", "ch0 silent on code 7", cntA, 0);
    check(cntB == 0, "R6", "ch1 silent on code 7", cntB, 0);
    cyc(4'b0, 1, 2'd0, 32'h7F00_FFFF);
    rd(2'd0, v); check(v == 32'h0, "R3", "ctrl unmasked bits dropped", v, 0);

    // R4: prescale sweep with N = 1, 2, 256 on ch0
    cyc(4'b0, 1, 2'd2, 32'h0000_0305);
    for (int p = 0; p < 4; p++) begin
      int ms [3] = '{0, 1, 255};
      for (int k = 0; k < 3; k++) begin
        int exp;
        exp = (2 << (2 * p)) * (ms[k] + 1);
        cyc(4'b0, 1, 2'd1, 32'((p << 8) | ms[k]));
        waitPulse(0, 4'b0001, 40000, n);
        check(n == exp, "R4", "first period after ratio write", n, exp);
        if (ms[k] != 255) begin
          waitPulse(0, 4'b0001, 40000, n2);
          check(n2 == exp, "R4", "steady period", n2, exp);
        end
      end
    end
    cyc(4'b0, 1, 2'd2, 32'h0000_01FF);
    waitPulse(1, 4'b0001, 40000, n);
    check(n == 2048, "R4", "ch1 p=1 N=256", n, 2048);

    // R5: code table, unselected inputs ignored
    cyc(4'b0, 1, 2'd1, 32'h2);
    cyc(4'b0, 1, 2'd2, 32'h2);
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = srcIdx(codes[k]);
      cyc(4'b0, 1, 2'd0, 32'((codes[k] << 20) | (codes[k] << 16)));
      cntA = 0;
      repeat (40) begin
        cyc(4'b1111 & ~(4'b1 << idx), 0, 2'd0, 32'd0);
        cntA += rateTick[0] + rateTick[1];
      end
      check(cntA == 0, "R5", "unselected inputs counted", cntA, 0);
      waitPulse(0, 4'b1 << idx, 50, n);
      check(n == 6, "R5", "selected input period", n, 6);
      check(rateTick[1] == 1'b1, "R5", "ch1 selected input", rateTick[1], 1);
    end

    // R7 / R10: mid-period restart of ch0 only
    cyc(4'b0, 1, 2'd0, 32'h0);
    cyc(4'b0, 1, 2'd1, 32'h3);
    cyc(4'b0, 1, 2'd2, 32'h3);
    repeat (5) cyc(4'b0001, 0, 2'd0, 32'd0);
    cyc(4'b0001, 1, 2'd1, 32'h3);
    aFirst = 0; bFirst = 0;
    for (int k = 1; k <= 10; k++) begin
      cyc(4'b0001, 0, 2'd0, 32'd0);
      if (rateTick[0] && aFirst == 0) aFirst = k;
      if (rateTick[1] && bFirst == 0) bFirst = k;
    end
    check(aFirst == 8, "R7", "full period after restart", aFirst, 8);
    check(bFirst == 2, "R10", "other channel undisturbed", bFirst, 2);

    // R9: master output selection
    cyc(4'b0, 1, 2'd1, 32'h0);
    cyc(4'b0, 1, 2'd2, 32'h2);
    cyc(4'b0, 1, 2'd0, 32'h8000_0000);
    cntA = 0;
    repeat (12) begin cyc(4'b1111, 0, 2'd0, 32'd0); cntA += mstrTick; end
    check(cntA == 2, "R9", "master follows ch1", cntA, 2);
    cyc(4'b0, 1, 2'd0, 32'h0);
    cntA = 0;
    repeat (12) begin cyc(4'b1111, 0, 2'd0, 32'd0); cntA += mstrTick; end
    check(cntA == 6, "R9", "master follows ch0", cntA, 6);

    // random: sources, ratios, ticks and writes against the model
    for (int r = 0; r < 24; r++) begin
      cyc(4'b0, 1, 2'd1, $urandom & 32'hFFFF_F10F);
      cyc(4'b0, 1, 2'd2, $urandom & 32'hFFFF_F10F);
      cyc(4'b0, 1, 2'd0, $urandom);
      repeat (300) begin
        if ($urandom % 64 == 0) begin
          logic [1:0] a;
          a = 2'($urandom % 3);
          cyc(4'($urandom), 1, a, (a == 0) ? $urandom : ($urandom & 32'hFFFF_F10F));
        end else begin
          cyc(4'($urandom), 0, 2'd0, 32'd0);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule